// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits on the slave side of a bus fabric and serves one alias window in which every 32-bit alias word stands for a single bit of real memory. A read through the window returns that one bit as 0 or 1. A write through the window changes only that bit. The bridge does this with a read-modify-write on its master port, and no other master transaction can come between the read and the write-back.

The slave port carries one request at a time: address, access size, write flag and write data, with a valid/ready handshake and a one-cycle response pulse. The master port issues unit-sized reads and writes to the backing memory. Master read data comes back later, on a separate valid strobe. A chip uses two instances. One maps the alias window at 0x2200_0000 onto memory at 0x2000_0000. The other maps 0x4200_0000 onto peripherals at 0x4000_0000. Only the base parameter differs between them. The enclosing fabric decodes which window an access falls in.

Top module: `bb_alias_bridge`

## Requirements
- R1: The master target address is `BASE_ADDR | (off >> 5)`, where `off` is the low 25 bits of the slave address. Address bits above the window do not take part.
- R2: The bit index is `off[6:2]`, masked to 3 bits for byte accesses, 4 bits for halfword accesses and 5 bits for word accesses. The size codes are 0 = byte, 1 = halfword, 2 = word, and code 3 is treated as word.
- R3: For halfword accesses the target address has bit 0 cleared. For word accesses it has bits 1:0 cleared. The master size equals the normalised slave size.
- R4: An alias read issues exactly one master read and no master write. Its response carries the indexed bit of the fetched unit in `s_rdata[0]`, and every higher bit is zero.
- R5: An alias write issues one master read and then one master write to the same address. The write sets the indexed bit if `s_wdata[0]` is 1 and clears it otherwise. Every other bit of the unit is unchanged, and `s_wdata[31:1]` has no effect.
- R6: From acceptance until its response, an access holds `s_ready` low. No other master transaction falls between the read and the write-back of one alias write.
- R7: Master data is right-aligned and little-endian. The byte at the target address is in bits 7:0, the next byte is in bits 15:8, and so on. Bit k of the unit is bit k%8 of byte k/8.
- R8: After reset `s_ready` is 1, and `m_valid` and `s_rvalid` are 0.
- R9: `s_rvalid` pulses for exactly one cycle per access. `s_ready` is already high in that cycle, so a new request can be accepted in the same cycle as the previous response.
- R10: A master request that is not yet accepted keeps `m_valid`, `m_write` and `m_addr` stable until `m_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Slave request valid |
| s_ready | output | 1 | Slave request accepted when high with s_valid |
| s_write | input | 1 | 1 = alias write, 0 = alias read |
| s_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| s_addr | input | ADDR_W | Alias address |
| s_wdata | input | DATA_W | Write data, only bit 0 used |
| s_rvalid | output | 1 | One-cycle response strobe |
| s_rdata | output | DATA_W | Read bit in bit 0, zeros above |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Master request accepted |
| m_write | output | 1 | Master write flag |
| m_size | output | 2 | Normalised unit size |
| m_addr | output | ADDR_W | Aligned target byte address |
| m_wdata | output | DATA_W | Right-aligned write-back unit |
| m_rvalid | input | 1 | Master read data strobe |
| m_rdata | input | DATA_W | Right-aligned read unit |

## Verification
The bridge can return one access's response and accept the next request in the same cycle. This case is provoked by having the bench raise the next request at the very sampling point where it sees the previous response. The bench counts these overlaps and requires at least one. Each following access is then judged on its own: its master transaction counts, its target address and the resulting memory unit must match the bench's reference model. If a response leaked into the next access or a request was lost, those comparisons would fail. Random stalls on `m_ready` and random read latency spread the response cycle over many positions relative to the master handshakes.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WBACK = 2'd2
    } bb_state_e;

    // size code 3 is folded onto word
    function automatic logic [1:0] norm_size(input logic [1:0] sz);
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          WIN_W     = 25,
    parameter logic [31:0] BASE_ADDR = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0]         alias_addr,
    input  logic [1:0]                size_n,
    output logic [ADDR_W-1:0]         tgt_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int SHIFT = $clog2(DATA_W / 8) + 3;

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] align_mask;
    logic [IDX_W-1:0]  idx_mask;

    always_comb begin
        off        = {{(ADDR_W-WIN_W){1'b0}}, alias_addr[WIN_W-1:0]};
        raw        = ADDR_W'(BASE_ADDR) | (off >> SHIFT);
        align_mask = ~((ADDR_W'(1) << size_n) - ADDR_W'(1));
        idx_mask   = IDX_W'((32'd8 << size_n) - 32'd1);
        tgt_addr   = raw & align_mask;
        bit_idx    = alias_addr[IDX_W+1:2] & idx_mask;
    end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         unit_in,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic                      new_bit,
    output logic                      bit_val,
    output logic [DATA_W-1:0]         unit_out
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel      = DATA_W'(1) << bit_idx;
        bit_val  = |(unit_in & sel);
        unit_out = new_bit ? (unit_in | sel) : (unit_in & ~sel);
    end

endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
    import bb_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          WIN_W     = 25,
    parameter logic [31:0] BASE_ADDR = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_write,
    input  logic [1:0]        s_size,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_rvalid,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_write,
    output logic [1:0]        m_size,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata
);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        bb_state_e         state;
        logic              issued;
        logic              is_wr;
        logic              wbit;
        logic [1:0]        size;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] tgt;
        logic [DATA_W-1:0] unit;
        logic              resp_v;
        logic              resp_bit;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]        req_size_n;
    logic [ADDR_W-1:0] req_tgt;
    logic [IDX_W-1:0]  req_idx;
    logic              rd_bit;
    logic [DATA_W-1:0] merged;

    assign req_size_n = norm_size(s_size);

    bb_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .BASE_ADDR(BASE_ADDR)
    ) u_map (
        .alias_addr (s_addr),
        .size_n     (req_size_n),
        .tgt_addr   (req_tgt),
        .bit_idx    (req_idx)
    );

    bb_bit_merge #(.DATA_W(DATA_W)) u_merge (
        .unit_in  (m_rdata),
        .bit_idx  (r_q.idx),
        .new_bit  (r_q.wbit),
        .bit_val  (rd_bit),
        .unit_out (merged)
    );

    // outputs derived from registered state only
    always_comb begin
        s_ready  = (r_q.state == ST_IDLE);
        s_rvalid = r_q.resp_v;
        s_rdata  = {{(DATA_W-1){1'b0}}, r_q.resp_bit};
        m_valid  = ((r_q.state == ST_READ) && !r_q.issued) || (r_q.state == ST_WBACK);
        m_write  = (r_q.state == ST_WBACK);
        m_size   = r_q.size;
        m_addr   = r_q.tgt;
        m_wdata  = r_q.unit;
    end

    always_comb begin
        r_d          = r_q;
        r_d.resp_v   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (s_valid) begin
                    r_d.state    = ST_READ;
                    r_d.issued   = 1'b0;
                    r_d.is_wr    = s_write;
                    r_d.wbit     = s_wdata[0];
                    r_d.size     = req_size_n;
                    r_d.idx      = req_idx;
                    r_d.tgt      = req_tgt;
                    r_d.resp_bit = 1'b0;
                end
            end
            ST_READ: begin
                if (!r_q.issued && m_ready) begin
                    r_d.issued = 1'b1;
                end
                if (r_q.issued && m_rvalid) begin
                    if (r_q.is_wr) begin
                        r_d.unit  = merged;
                        r_d.state = ST_WBACK;
                    end else begin
                        r_d.resp_v   = 1'b1;
                        r_d.resp_bit = rd_bit;
                        r_d.state    = ST_IDLE;
                    end
                end
            end
            ST_WBACK: begin
                if (m_ready) begin
                    r_d.resp_v   = 1'b1;
                    r_d.resp_bit = 1'b0;
                    r_d.state    = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/bb_alias_bridge_chk.sv
module bb_alias_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              s_rvalid,
    input logic [DATA_W-1:0] s_rdata,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_write,
    input logic [1:0]        m_size,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_rvalid,
    input logic [DATA_W-1:0] m_rdata
);
    logic              have_rd;
    logic [ADDR_W-1:0] last_rd_addr;
    logic [DATA_W-1:0] last_rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_rd      <= 1'b0;
            last_rd_addr <= '0;
            last_rd_data <= '0;
        end else begin
            if (m_valid && m_ready && !m_write) begin
                have_rd      <= 1'b1;
                last_rd_addr <= m_addr;
            end
            if (m_rvalid) begin
                last_rd_data <= m_rdata;
            end
        end
    end

    AST_RDATA_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> (s_rdata[DATA_W-1:1] == '0)); // R4

    AST_WBACK_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write) |-> (have_rd && m_addr == last_rd_addr)); // R5

    AST_WBACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write) |-> ($countones(m_wdata ^ last_rd_data) <= 1)); // R5

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready); // R6

    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready); // R6

    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size == 2'd1) |-> (m_addr[0] == 1'b0)); // R3

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size == 2'd2) |-> (m_addr[1:0] == 2'b00)); // R3

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |=> !s_rvalid); // R9

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write))); // R10

endmodule

bind bb_alias_bridge bb_alias_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_rvalid (s_rvalid),
    .s_rdata  (s_rdata),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_write  (m_write),
    .m_size   (m_size),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_rvalid (m_rvalid),
    .m_rdata  (m_rdata)
);

// File: tb/bb_alias_bridge_tb.sv
module bb_alias_bridge_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h2000_0000;
    localparam logic [31:0] ALIAS      = 32'h2200_0000;
    localparam int          WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_write = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready, s_rvalid;
    logic [31:0] s_rdata;
    logic        m_valid, m_write;
    logic [1:0]  m_size;
    logic [31:0] m_addr, m_wdata;
    logic        m_ready = 1'b0, m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_alias_bridge #(.BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_size(s_size),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
        .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_size(m_size),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
    );

    int checks = 0, failures = 0;
    int stall_checks = 0, stall_fails = 0;
    int overlaps = 0;
    bit timeout = 1'b0;

    logic [7:0]  mem     [0:1023];
    logic [7:0]  exp_mem [0:1023];
    int          n_rd = 0, n_wr = 0;
    logic [31:0] rd_addr_seen = '0, wr_addr_seen = '0;
    logic        rd_pend = 1'b0;
    int          rd_delay = 0;
    logic [31:0] rd_val = '0;
    logic        stall_pend = 1'b0, stall_wr = 1'b0;
    logic [31:0] stall_addr = '0;

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] f_tgt(input logic [24:0] off, input logic [1:0] sz);
        logic [31:0] t;
        t = BASE | ({7'b0, off} >> 5);
        if (sz == 2'd1) t[0] = 1'b0;
        if (sz >= 2'd2) t[1:0] = 2'b00;
        return t;
    endfunction

    function automatic int f_idx(input logic [24:0] off, input logic [1:0] sz);
        return int'(off[6:2]) & (nbytes(sz) * 8 - 1);
    endfunction

    function automatic logic [31:0] exp_unit(input logic [31:0] a, input int nb);
        logic [31:0] u;
        u = '0;
        for (int i = 0; i < nb; i++) u[8*i +: 8] = exp_mem[(int'(a[9:0]) + i) % 1024];
        return u;
    endfunction

    // backing memory: random ready, random read latency, right-aligned little-endian data
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready  <= 1'b0;
            m_rvalid <= 1'b0;
            rd_pend  <= 1'b0;
            stall_pend <= 1'b0;
        end else begin
            m_ready  <= ($urandom % 4) != 0;
            m_rvalid <= 1'b0;
            if (rd_pend) begin
                if (rd_delay == 0) begin
                    m_rvalid <= 1'b1;
                    m_rdata  <= rd_val;
                    rd_pend  <= 1'b0;
                end else begin
                    rd_delay <= rd_delay - 1;
                end
            end
            if (m_valid && m_ready) begin
                if (m_write) begin
                    for (int i = 0; i < nbytes(m_size); i++)
                        mem[(int'(m_addr[9:0]) + i) % 1024] <= m_wdata[8*i +: 8];
                    n_wr <= n_wr + 1;
                    wr_addr_seen <= m_addr;
                end else begin
                    logic [31:0] v;
                    v = '0;
                    for (int i = 0; i < nbytes(m_size); i++)
                        v[8*i +: 8] = mem[(int'(m_addr[9:0]) + i) % 1024];
                    rd_val   <= v;
                    rd_pend  <= 1'b1;
                    rd_delay <= $urandom % 3;
                    n_rd <= n_rd + 1;
                    rd_addr_seen <= m_addr;
                end
            end
            if (stall_pend) begin
                stall_checks++;
                if (!m_valid || m_addr != stall_addr || m_write != stall_wr) begin
                    stall_fails++;
                    $display("FAIL R10 stalled request changed: valid=%0b addr=%h wr=%0b expected addr=%h wr=%0b",
                             m_valid, m_addr, m_write, stall_addr, stall_wr);
                end
            end
            stall_pend <= m_valid && !m_ready;
            stall_addr <= m_addr;
            stall_wr   <= m_write;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic wr, input logic [1:0] sz, input logic [24:0] off,
                             input logic [31:0] wd, input logic [6:0] upper);
        int rd0, wr0, nb, idx;
        logic [31:0] et, u, got;
        et  = f_tgt(off, sz);
        idx = f_idx(off, sz);
        nb  = nbytes(sz);
        u   = exp_unit(et, nb);
        rd0 = n_rd;
        wr0 = n_wr;
        if (s_rvalid && s_ready) overlaps++;
        s_valid = 1'b1; s_write = wr; s_size = sz; s_wdata = wd;
        s_addr  = {upper, off};
        while (!s_ready && !timeout) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        while (!s_rvalid && !timeout) @(negedge clk);
        if (timeout) return;
        check(n_rd - rd0 == 1, "R4/R5 master read count", n_rd - rd0, 1);
        check(n_wr - wr0 == int'(wr), "R4/R5 master write count", n_wr - wr0, {31'b0, wr});
        check(rd_addr_seen == et, "R1/R2/R3 read target address", rd_addr_seen, et);
        if (!wr) begin
            check(s_rdata == {31'b0, u[idx]}, "R4/R7 read bit", s_rdata, {31'b0, u[idx]});
        end else begin
            check(wr_addr_seen == et, "R5 write-back address", wr_addr_seen, et);
            u[idx] = wd[0];
            for (int i = 0; i < nb; i++) exp_mem[(int'(et[9:0]) + i) % 1024] = u[8*i +: 8];
            got = '0;
            for (int i = 0; i < nb; i++) got[8*i +: 8] = mem[(int'(et[9:0]) + i) % 1024];
            check(got == u, "R5/R7 memory unit after write", got, u);
        end
    endtask

    task automatic run_all();
        // R8 reset state
        check(s_ready == 1'b1, "R8 s_ready after reset", {31'b0, s_ready}, 1);
        check(m_valid == 1'b0, "R8 m_valid after reset", {31'b0, m_valid}, 0);
        check(s_rvalid == 1'b0, "R8 s_rvalid after reset", {31'b0, s_rvalid}, 0);
        // R1 R2 R3 directed: top of window, word index 31
        do_access(1'b0, 2'd2, 25'h1FF_FFFC, 32'h0, 7'h11);
        do_access(1'b1, 2'd2, 25'h1FF_FFFC, 32'h1, 7'h11);
        do_access(1'b0, 2'd2, 25'h1FF_FFFC, 32'h0, 7'h11);
        do_access(1'b1, 2'd2, 25'h1FF_FFFC, 32'hFFFF_FFFE, 7'h11); // R5 only bit0 counts
        do_access(1'b0, 2'd2, 25'h1FF_FFFC, 32'h0, 7'h11);
        // R2 byte index 7 and halfword index 15, size code 3 as word
        do_access(1'b1, 2'd0, 25'h00_007C, 32'h1, 7'h11);
        do_access(1'b0, 2'd0, 25'h00_007C, 32'h0, 7'h11);
        do_access(1'b1, 2'd1, 25'h00_00BC, 32'h0, 7'h11);
        do_access(1'b0, 2'd1, 25'h00_00BC, 32'h0, 7'h11);
        do_access(1'b1, 2'd3, 25'h00_0FE4, 32'h1, 7'h11);
        do_access(1'b0, 2'd3, 25'h00_0FE4, 32'h0, 7'h11);
        // R1 upper address bits ignored
        do_access(1'b0, 2'd0, 25'h00_1234, 32'h0, 7'h55);
        // random mix
        for (int n = 0; n < 600 && !timeout; n++) begin
            do_access(1'($urandom % 2), 2'($urandom % 4), 25'($urandom % 32768),
                      $urandom, 7'h11);
        end
        check(overlaps > 0, "R9 response and acceptance in one cycle", overlaps, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=completion", WD_CYCLES);
        end
        checks   += stall_checks;
        failures += stall_fails;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule